// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block provides the interlock for a five-stage in-order pipeline (fetch, decode, execute, memory access, write-back) that has no bypass network. While an instruction sits in decode, its two source register indices are compared with the destination index of the instruction in execute. If the execute instruction is valid, writes a register and targets a nonzero index that matches either source, decode cannot proceed.

On such a match the program counter and the fetch/decode latch keep their contents for one cycle. A no-operation bubble is loaded into the decode/execute latch in place of the waiting instruction, and the later stages keep advancing. The writer therefore leaves execute. In the next cycle the held instruction moves on, and the bubble travels down to write-back without enabling a write.

Minimal stage latches are included. They carry a valid flag, a write-enable flag and the register indices, so that stall behaviour can be observed at the ports. The instruction store lies outside the block and returns one instruction per cycle for the current program counter.

Top module: `hazard_stall_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the program counter to 0. Every stage latch becomes invalid, with its write-enable and destination index at 0.
- R2: With no hazard, `pcWriteEn` and `ifidWriteEn` are 1 and `idexBubble` is 0. The program counter grows by `PC_STEP` (4 by default) every cycle, and each instruction advances one stage per cycle.
- R3: A hazard is flagged (`pcWriteEn`=0, `ifidWriteEn`=0, `idexBubble`=1) when the decode instruction is valid, the execute instruction is valid with write-enable 1 and a nonzero destination, and that destination equals the decode source 1 index or the decode source 2 index.
- R4: No hazard is flagged when the execute instruction does not write, when its destination index is 0, when the execute stage is invalid, or when the decode stage is invalid. An invalid fetched instruction enters the pipeline with write-enable forced to 0.
- R5: During a stall cycle the program counter and the decode latch (valid, destination) keep their values across the clock edge.
- R6: During a stall cycle the execute latch receives a bubble: valid 0, write-enable 0, destination 0.
- R7: During a stall cycle the memory and write-back latches still advance, so the conflicting writer moves from execute into memory.
- R8: A single hazard stalls for exactly one cycle. The held decode instruction then enters execute, and the program counter resumes stepping.
- R9: Only the execute stage is compared. A writer in the memory stage whose destination matches a decode source causes no stall.
- R10: A bubble reaches the memory and write-back latches with valid 0 and write-enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetchValid | input | 1 | Fetched instruction is real |
| fetchWen | input | 1 | Fetched instruction writes a register |
| fetchRd | input | 5 | Fetched destination index |
| fetchRs1 | input | 5 | Fetched source 1 index |
| fetchRs2 | input | 5 | Fetched source 2 index |
| pcOut | output | 32 | Current program counter (fetch address) |
| pcWriteEn | output | 1 | Program counter may update this cycle |
| ifidWriteEn | output | 1 | Fetch/decode latch may load this cycle |
| idexBubble | output | 1 | Execute latch loads a bubble this cycle |
| idValid | output | 1 | Decode stage valid |
| idRd | output | 5 | Decode stage destination |
| exValid | output | 1 | Execute stage valid |
| exWen | output | 1 | Execute stage write-enable |
| exRd | output | 5 | Execute stage destination |
| memValid | output | 1 | Memory stage valid |
| memWen | output | 1 | Memory stage write-enable |
| memRd | output | 5 | Memory stage destination |
| wbValid | output | 1 | Write-back stage valid |
| wbWen | output | 1 | Write-back stage write-enable |
| wbRd | output | 5 | Write-back stage destination |

## Verification
In a single cycle, the hold of the front of the pipeline and the forward motion of its back can both occur: the program counter and decode latch freeze while the writer moves from execute into memory. A dependent chain provokes this, with each instruction reading the register written by the one before it. That chain forces a stall, then normal advance, then a second stall two cycles later. After every edge the bench checks the program counter, the decode latch, the bubble in execute and the writer's position in memory against a hand-computed cycle schedule. It also follows the bubble into write-back, where it must show no write.

// File: rtl/hazard_pkg.sv
`timescale 1ns/1ps
package hazard_pkg;
  parameter int REG_IDX_W = 5;
  parameter int PC_W = 32;

  typedef logic [REG_IDX_W-1:0] regIdx_t;

  // Full instruction view held in the fetch/decode latch.
  typedef struct packed {
    logic    valid;
    logic    wen;
    regIdx_t rd;
    regIdx_t rs1;
    regIdx_t rs2;
  } instr_t;

  // Reduced view carried from execute onward.
  typedef struct packed {
    logic    valid;
    logic    wen;
    regIdx_t rd;
  } stageTag_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic pcWrite;
    logic ifidWrite;
    logic idexBubble;
  } stallCtrl_t;

  localparam stageTag_t BUBBLE_TAG = '{valid: 1'b0, wen: 1'b0, rd: '0};
endpackage

// File: rtl/hazard_control.sv
`timescale 1ns/1ps
module hazard_control
  import hazard_pkg::*;
(
  input  instr_t     idInstr,
  input  stageTag_t  exTag,
  output stallCtrl_t ctrl
);
  logic exWrites;
  logic srcMatch;
  logic hazard;

  always_comb begin
    exWrites = exTag.valid && exTag.wen && (exTag.rd != '0);
    srcMatch = (idInstr.rs1 == exTag.rd) || (idInstr.rs2 == exTag.rd);
    hazard   = idInstr.valid && exWrites && srcMatch;
    ctrl.pcWrite    = !hazard;
    ctrl.ifidWrite  = !hazard;
    ctrl.idexBubble = hazard;
  end
endmodule

// File: rtl/hazard_datapath.sv
`timescale 1ns/1ps
module hazard_datapath
  import hazard_pkg::*;
#(
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  instr_t          fetchInstr,
  input  stallCtrl_t      ctrl,
  output logic [PC_W-1:0] pc,
  output instr_t          idInstr,
  output stageTag_t       exTag,
  output stageTag_t       memTag,
  output stageTag_t       wbTag
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  instr_t    fetchClean;
  stageTag_t idTag;

  always_comb begin
    fetchClean     = fetchInstr;
    fetchClean.wen = fetchInstr.valid && fetchInstr.wen;
    idTag.valid    = idInstr.valid;
    idTag.wen      = idInstr.wen;
    idTag.rd       = idInstr.rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      idInstr <= '0;
      exTag   <= BUBBLE_TAG;
      memTag  <= BUBBLE_TAG;
      wbTag   <= BUBBLE_TAG;
    end else begin
      if (ctrl.pcWrite)   pc      <= pc + STEP;
      if (ctrl.ifidWrite) idInstr <= fetchClean;
      exTag  <= ctrl.idexBubble ? BUBBLE_TAG : idTag;
      memTag <= exTag;
      wbTag  <= memTag;
    end
  end

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    ctrl.pcWrite |=> pc == $past(pc) + STEP);
  a_r5_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.pcWrite |=> pc == $past(pc));
  a_r5_ifid_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.ifidWrite |=> idInstr == $past(idInstr));
  a_r6_bubble_enters: assert property (@(posedge clk) disable iff (rst)
    ctrl.idexBubble |=> (!exTag.valid && !exTag.wen));
  a_r7_writer_moves: assert property (@(posedge clk) disable iff (rst)
    ctrl.idexBubble |=> memTag == $past(exTag));
  a_r8_single_stall: assert property (@(posedge clk) disable iff (rst)
    ctrl.idexBubble |=> !ctrl.idexBubble);
  a_r4_no_write_no_stall: assert property (@(posedge clk) disable iff (rst)
    (!exTag.wen || exTag.rd == '0) |-> !ctrl.idexBubble);
  a_r10_invalid_mem_quiet: assert property (@(posedge clk) disable iff (rst)
    !memTag.valid |-> !memTag.wen);
  a_r10_invalid_wb_quiet: assert property (@(posedge clk) disable iff (rst)
    !wbTag.valid |-> !wbTag.wen);
endmodule

// File: rtl/hazard_stall_top.sv
`timescale 1ns/1ps
module hazard_stall_top
  import hazard_pkg::*;
#(
  parameter int PC_STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetchValid,
  input  logic                 fetchWen,
  input  logic [REG_IDX_W-1:0] fetchRd,
  input  logic [REG_IDX_W-1:0] fetchRs1,
  input  logic [REG_IDX_W-1:0] fetchRs2,
  output logic [PC_W-1:0]      pcOut,
  output logic                 pcWriteEn,
  output logic                 ifidWriteEn,
  output logic                 idexBubble,
  output logic                 idValid,
  output logic [REG_IDX_W-1:0] idRd,
  output logic                 exValid,
  output logic                 exWen,
  output logic [REG_IDX_W-1:0] exRd,
  output logic                 memValid,
  output logic                 memWen,
  output logic [REG_IDX_W-1:0] memRd,
  output logic                 wbValid,
  output logic                 wbWen,
  output logic [REG_IDX_W-1:0] wbRd
);
  instr_t     fetchInstr;
  instr_t     idInstr;
  stageTag_t  exTag, memTag, wbTag;
  stallCtrl_t ctrl;

  always_comb begin
    fetchInstr.valid = fetchValid;
    fetchInstr.wen   = fetchWen;
    fetchInstr.rd    = fetchRd;
    fetchInstr.rs1   = fetchRs1;
    fetchInstr.rs2   = fetchRs2;
  end

  hazard_control u_ctrl (
    .idInstr (idInstr),
    .exTag   (exTag),
    .ctrl    (ctrl)
  );

  hazard_datapath #(.PC_STEP(PC_STEP)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .fetchInstr (fetchInstr),
    .ctrl       (ctrl),
    .pc         (pcOut),
    .idInstr    (idInstr),
    .exTag      (exTag),
    .memTag     (memTag),
    .wbTag      (wbTag)
  );

  assign pcWriteEn   = ctrl.pcWrite;
  assign ifidWriteEn = ctrl.ifidWrite;
  assign idexBubble  = ctrl.idexBubble;
  assign idValid     = idInstr.valid;
  assign idRd        = idInstr.rd;
  assign exValid     = exTag.valid;
  assign exWen       = exTag.wen;
  assign exRd        = exTag.rd;
  assign memValid    = memTag.valid;
  assign memWen      = memTag.wen;
  assign memRd       = memTag.rd;
  assign wbValid     = wbTag.valid;
  assign wbWen       = wbTag.wen;
  assign wbRd        = wbTag.rd;
endmodule

// File: tb/tb_hazard_stall_top.sv
`timescale 1ns/1ps
module tb_hazard_stall_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic fetchValid, fetchWen;
  logic [4:0] fetchRd, fetchRs1, fetchRs2;
  logic [31:0] pcOut;
  logic pcWriteEn, ifidWriteEn, idexBubble, idValid, exValid, exWen;
  logic memValid, memWen, wbValid, wbWen;
  logic [4:0] idRd, exRd, memRd, wbRd;

  hazard_stall_top dut (
    .clk(clk), .rst(rst),
    .fetchValid(fetchValid), .fetchWen(fetchWen), .fetchRd(fetchRd),
    .fetchRs1(fetchRs1), .fetchRs2(fetchRs2),
    .pcOut(pcOut), .pcWriteEn(pcWriteEn), .ifidWriteEn(ifidWriteEn),
    .idexBubble(idexBubble), .idValid(idValid), .idRd(idRd),
    .exValid(exValid), .exWen(exWen), .exRd(exRd),
    .memValid(memValid), .memWen(memWen), .memRd(memRd),
    .wbValid(wbValid), .wbWen(wbWen), .wbRd(wbRd)
  );

  // Bench-side instruction store, 8 slots, word addressed by pcOut/4.
  logic       progV[8], progW[8];
  logic [4:0] progRd[8], progS1[8], progS2[8];

  always_comb begin
    if (pcOut < 32'd32) begin
      fetchValid = progV[pcOut[4:2]];
      fetchWen   = progW[pcOut[4:2]];
      fetchRd    = progRd[pcOut[4:2]];
      fetchRs1   = progS1[pcOut[4:2]];
      fetchRs2   = progS2[pcOut[4:2]];
    end else begin
      fetchValid = 1'b0; fetchWen = 1'b0;
      fetchRd = '0; fetchRs1 = '0; fetchRs2 = '0;
    end
  end

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 8; i++) begin
      progV[i] = 1'b0; progW[i] = 1'b0;
      progRd[i] = '0; progS1[i] = '0; progS2[i] = '0;
    end
  endtask

  task automatic setI(int idx, logic v, logic w, int rd, int s1, int s2);
    progV[idx] = v; progW[idx] = w;
    progRd[idx] = 5'(rd); progS1[idx] = 5'(s1); progS2[idx] = 5'(s2);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chkStall(string req, bit exp);
    chk(req, "pcWriteEn", pcWriteEn, !exp);
    chk(req, "ifidWriteEn", ifidWriteEn, !exp);
    chk(req, "idexBubble", idexBubble, exp);
  endtask

  task automatic testReset();
    clearProg();
    setI(0, 1, 1, 3, 1, 2);
    doReset();
    chk("R1", "pc", pcOut, 0);
    chk("R1", "idValid", idValid, 0);
    chk("R1", "exValid", exValid, 0);
    chk("R1", "exWen", exWen, 0);
    chk("R1", "memValid", memValid, 0);
    chk("R1", "wbValid", wbValid, 0);
    chk("R1", "wbRd", wbRd, 0);
    chkStall("R1", 0);
  endtask

  task automatic testNoHazard();
    clearProg();
    setI(0, 1, 1, 1, 0, 0);
    setI(1, 1, 1, 4, 2, 3);
    setI(2, 1, 1, 5, 6, 7);
    doReset();
    step(); chk("R2", "pc e1", pcOut, 4); chk("R2", "idRd e1", idRd, 1);
    step(); chkStall("R2", 0); chk("R2", "exRd e2", exRd, 1);
    step();
    chk("R2", "pc e3", pcOut, 12);
    chk("R2", "exRd e3", exRd, 4);
    chk("R2", "memRd e3", memRd, 1);
    chk("R2", "idRd e3", idRd, 5);
  endtask

  task automatic testHazard(bit useRs2);
    string rq = useRs2 ? "R3 rs2" : "R3 rs1";
    clearProg();
    setI(0, 1, 1, 7, 0, 0);
    if (useRs2) setI(1, 1, 1, 8, 2, 7);
    else        setI(1, 1, 1, 8, 7, 2);
    setI(2, 1, 1, 9, 3, 4);
    doReset();
    step(); step();
    chkStall(rq, 1);
    step();
    chk("R5", "pc held", pcOut, 8);
    chk("R5", "idRd held", idRd, 8);
    chk("R5", "idValid held", idValid, 1);
    chk("R6", "exValid bubble", exValid, 0);
    chk("R6", "exWen bubble", exWen, 0);
    chk("R6", "exRd bubble", exRd, 0);
    chk("R7", "memRd writer", memRd, 7);
    chk("R7", "memWen writer", memWen, 1);
    chkStall("R8 one cycle", 0);
    step();
    chk("R8", "exRd resumed", exRd, 8);
    chk("R8", "pc resumed", pcOut, 12);
    chk("R8", "idRd next", idRd, 9);
    chk("R10", "memValid bubble", memValid, 0);
    chk("R10", "memWen bubble", memWen, 0);
    chk("R7", "wbRd writer", wbRd, 7);
    step();
    chk("R10", "wbValid bubble", wbValid, 0);
    chk("R10", "wbWen bubble", wbWen, 0);
  endtask

  task automatic testNoWrite();
    clearProg();
    setI(0, 1, 0, 7, 0, 0);
    setI(1, 1, 1, 8, 7, 7);
    doReset();
    step(); step();
    chkStall("R4 ex wen0", 0);
    clearProg();
    setI(0, 1, 1, 0, 0, 0);
    setI(1, 1, 1, 8, 0, 0);
    doReset();
    step(); step();
    chkStall("R4 ex rd0", 0);
  endtask

  task automatic testInvalid();
    clearProg();
    setI(0, 1, 1, 6, 0, 0);
    setI(1, 0, 1, 8, 6, 6);
    doReset();
    step(); step();
    chkStall("R4 id invalid", 0);
    clearProg();
    setI(0, 0, 1, 6, 0, 0);
    setI(1, 1, 1, 8, 6, 6);
    doReset();
    step(); step();
    chk("R4", "invalid ex wen", exWen, 0);
    chkStall("R4 ex invalid", 0);
  endtask

  task automatic testMemWriter();
    clearProg();
    setI(0, 1, 1, 1, 0, 0);
    setI(1, 1, 1, 2, 5, 6);
    setI(2, 1, 1, 3, 1, 1);
    doReset();
    step(); step();
    chkStall("R9 e2", 0);
    step();
    chk("R9", "memRd writer", memRd, 1);
    chkStall("R9 mem writer", 0);
    step();
    chk("R9", "exRd reader", exRd, 3);
  endtask

  task automatic testChain();
    clearProg();
    setI(0, 1, 1, 1, 0, 0);
    setI(1, 1, 1, 2, 1, 0);
    setI(2, 1, 1, 3, 2, 0);
    doReset();
    step(); step();
    chkStall("R3 chain first", 1);
    step();
    chk("R5", "chain pc hold", pcOut, 8);
    chk("R7", "chain memRd", memRd, 1);
    chkStall("R8 chain gap", 0);
    step();
    chk("R8", "chain exRd", exRd, 2);
    chkStall("R3 chain second", 1);
    step();
    chk("R5", "chain pc hold2", pcOut, 12);
    chk("R6", "chain exValid", exValid, 0);
    chk("R10", "chain wbValid", wbValid, 0);
    chk("R7", "chain memRd2", memRd, 2);
    step();
    chk("R8", "chain exRd2", exRd, 3);
  endtask

  initial begin
    clearProg();
    testReset();
    testNoHazard();
    testHazard(0);
    testHazard(1);
    testNoWrite();
    testInvalid();
    testMemWriter();
    testChain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule